// File: doc/BRIEF.md
# Dual Comparator Input Routing Controller

This block is the digital model of a peripheral that holds two magnitude comparators. Four pin sample codes and one internal reference code, all unsigned, come in on every cycle. A 3-bit mode field and a one-bit input-select flag decide three things:
- which codes reach the plus and minus input of each comparator;
- which of the four pins count as analog;
- whether the comparator results drive two port pins.

Software works through a single byte-wide control/status register. It writes the mode and the input-select flag. It reads back the two comparator results and the configuration. Each comparator result passes through a two-stage synchronizer before it is stored. A change flag rises whenever the stored results differ from the value captured at the last register read. The flag stays set until a clear input removes it.

Top module: `cmp_route_top`

## Requirements
- R1: After reset, the register reads 0x00. Register bits 2:0 hold the mode and bit 3 holds the input-select flag, and both read back as written. Bits 5:4 always read 0.
- R2: In mode 000, both comparator results read 0 and the analog mask is 4'b1111 (bit i set means pin i is analog).
- R3: Mode 111 behaves as mode 000, except that the analog mask is 4'b0000.
- R4: In mode 100, comparator 1 compares plus = pin 3 against minus = pin 0, and comparator 2 compares plus = pin 2 against minus = pin 1. Analog mask 4'b1111.
- R5: In mode 010, both plus inputs take the reference. With select = 0 the minus inputs are pin 0 (comparator 1) and pin 1 (comparator 2); with select = 1 they are pin 3 and pin 2. Analog mask 4'b1111.
- R6: In mode 011, both plus inputs take pin 2, comparator 1 minus is pin 0, comparator 2 minus is pin 1, and the analog mask is 4'b0111. The output drives stay disabled.
- R7: Mode 110 routes as mode 011. In addition, the pin 3 drive is enabled with the comparator 1 result as data. The pin 4 drive is open-drain: its enable is set only while the comparator 2 result is 0, and its data is always 0.
- R8: In mode 101, comparator 1 is off and reads 0. Comparator 2 compares plus = pin 2 against minus = pin 1. Analog mask 4'b0110.
- R9: In mode 001, both plus inputs take pin 2 and comparator 2 minus is pin 1. Comparator 1 minus is pin 0 with select = 0 and pin 3 with select = 1. Analog mask 4'b1111.
- R10: A running comparator gives 1 when plus > minus and 0 when plus < minus. When plus = minus it keeps its previous result.
- R11: A change in the inputs shows up in register bits 7 (comparator 2) and 6 (comparator 1) after the third rising clock edge, and not earlier.
- R12: The change flag sets one cycle after the stored results differ from the value latched at the last read, unless a read happens in that cycle. The clear input drops the flag only when no new set condition is present, because setting takes priority.
- R13: Writes to register bits 7:4 have no effect on what is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe; latches current results for change detection |
| regRdData | output | 8 | Register read value |
| pinSamples | input | 32 | Four pin codes, pin i in bits 8i+7:8i |
| refCode | input | 8 | Internal reference code |
| flagClr | input | 1 | Change flag clear |
| analogMask | output | 4 | Bit i set: pin i is analog |
| pin3DriveEn | output | 1 | Pin 3 push-pull output enable |
| pin3DriveData | output | 1 | Pin 3 output value |
| pin4DriveEn | output | 1 | Pin 4 open-drain pull-down enable |
| pin4DriveData | output | 1 | Pin 4 output value (always 0) |
| changeFlag | output | 1 | Comparator change interrupt flag |

## Verification
Faults in the mode decode show up within four cycles after a write: the register bits 7:6, the analog mask or the pin drives are wrong. Each mode is run with pin values that make every routing choice give a distinct result pair. A wrong hold-on-equal state or a wrong synchronizer depth shows up as status bits that are stale or too early exactly at the third edge after an input change. A bad read latch shows up as a change flag that is wrongly set or wrongly cleared one cycle after a read or a clear.

// File: rtl/cmp_route_pkg.sv
package cmp_route_pkg;

  localparam int PIN_COUNT = 4;
  localparam int CMP_COUNT = 2;

  typedef enum logic [2:0] {
    SEL_PIN0 = 3'd0,
    SEL_PIN1 = 3'd1,
    SEL_PIN2 = 3'd2,
    SEL_PIN3 = 3'd3,
    SEL_REF  = 3'd4
  } srcSel_e;

  typedef struct packed {
    srcSel_e                minusSel1;
    srcSel_e                plusSel1;
    srcSel_e                minusSel2;
    srcSel_e                plusSel2;
    logic                   cmpOn1;
    logic                   cmpOn2;
    logic [PIN_COUNT-1:0]   pinAnalog;
    logic                   driveOut;
  } routeCtl_t;

  localparam logic [2:0] MODE_RESET   = 3'b000;
  localparam logic [2:0] MODE_TRIPLE  = 3'b001;
  localparam logic [2:0] MODE_REFMUX  = 3'b010;
  localparam logic [2:0] MODE_COMMON  = 3'b011;
  localparam logic [2:0] MODE_INDEP   = 3'b100;
  localparam logic [2:0] MODE_SINGLE  = 3'b101;
  localparam logic [2:0] MODE_COMOUT  = 3'b110;
  localparam logic [2:0] MODE_OFF     = 3'b111;

endpackage

// File: rtl/cmp_route_ctrl.sv
module cmp_route_ctrl
  import cmp_route_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [MODE_W:0]   wrCfg,
  output logic [MODE_W-1:0] modeOut,
  output logic              selOut,
  output routeCtl_t         ctl
);

  logic [MODE_W-1:0] modeReg;
  logic              selReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeReg <= '0;
      selReg  <= 1'b0;
    end else if (wrEn) begin
      modeReg <= wrCfg[MODE_W-1:0];
      selReg  <= wrCfg[MODE_W];
    end
  end

  assign modeOut = modeReg;
  assign selOut  = selReg;

  always_comb begin
    ctl = '{minusSel1: SEL_PIN0, plusSel1: SEL_PIN3,
            minusSel2: SEL_PIN1, plusSel2: SEL_PIN2,
            cmpOn1: 1'b0, cmpOn2: 1'b0, pinAnalog: 4'b1111, driveOut: 1'b0};
    case (modeReg)
      MODE_INDEP: begin
        ctl.cmpOn1 = 1'b1;
        ctl.cmpOn2 = 1'b1;
      end
      MODE_REFMUX: begin
        ctl.cmpOn1    = 1'b1;
        ctl.cmpOn2    = 1'b1;
        ctl.plusSel1  = SEL_REF;
        ctl.plusSel2  = SEL_REF;
        ctl.minusSel1 = selReg ? SEL_PIN3 : SEL_PIN0;
        ctl.minusSel2 = selReg ? SEL_PIN2 : SEL_PIN1;
      end
      MODE_COMMON, MODE_COMOUT: begin
        ctl.cmpOn1    = 1'b1;
        ctl.cmpOn2    = 1'b1;
        ctl.plusSel1  = SEL_PIN2;
        ctl.pinAnalog = 4'b0111;
        ctl.driveOut  = (modeReg == MODE_COMOUT);
      end
      MODE_SINGLE: begin
        ctl.cmpOn2    = 1'b1;
        ctl.pinAnalog = 4'b0110;
      end
      MODE_TRIPLE: begin
        ctl.cmpOn1    = 1'b1;
        ctl.cmpOn2    = 1'b1;
        ctl.plusSel1  = SEL_PIN2;
        ctl.minusSel1 = selReg ? SEL_PIN3 : SEL_PIN0;
      end
      MODE_OFF: ctl.pinAnalog = 4'b0000;
      default: ;
    endcase
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (modeOut == $past(wrCfg[MODE_W-1:0]) && selOut == $past(wrCfg[MODE_W]))); // R1

  AST_DRIVE_ONLY_DIGITAL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.driveOut |-> !ctl.pinAnalog[3]); // R7

endmodule

// File: rtl/cmp_route_dp.sv
module cmp_route_dp
  import cmp_route_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PIN_COUNT*DATA_W-1:0] pinBus,
  input  logic [DATA_W-1:0]           refCode,
  input  routeCtl_t                   ctl,
  input  logic                        rdEn,
  input  logic                        flagClr,
  output logic [CMP_COUNT-1:0]        status,
  output logic [PIN_COUNT-1:0]        pinAnalog,
  output logic                        p3En,
  output logic                        p3Data,
  output logic                        p4En,
  output logic                        p4Data,
  output logic                        flag
);

  logic [DATA_W-1:0]    pins [PIN_COUNT];
  srcSel_e              minusSel [CMP_COUNT];
  srcSel_e              plusSel  [CMP_COUNT];
  logic [CMP_COUNT-1:0] cmpOn;
  logic [CMP_COUNT-1:0] cmpState;
  logic [CMP_COUNT-1:0] syncA;
  logic [CMP_COUNT-1:0] syncB;
  logic [CMP_COUNT-1:0] lastRead;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    assign pins[p] = pinBus[p*DATA_W +: DATA_W];
  end

  assign minusSel[0] = ctl.minusSel1;
  assign plusSel[0]  = ctl.plusSel1;
  assign minusSel[1] = ctl.minusSel2;
  assign plusSel[1]  = ctl.plusSel2;
  assign cmpOn       = {ctl.cmpOn2, ctl.cmpOn1};

  for (genvar c = 0; c < CMP_COUNT; c++) begin : g_cmp
    logic [DATA_W-1:0] minusVal;
    logic [DATA_W-1:0] plusVal;
    logic [2:0]        minusIdx;
    logic [2:0]        plusIdx;

    always_comb begin
      minusIdx = minusSel[c];
      plusIdx  = plusSel[c];
      minusVal = (minusSel[c] == SEL_REF) ? refCode : pins[minusIdx[1:0]];
      plusVal  = (plusSel[c]  == SEL_REF) ? refCode : pins[plusIdx[1:0]];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !cmpOn[c]) cmpState[c] <= 1'b0;
      else if (plusVal > minusVal) cmpState[c] <= 1'b1;
      else if (plusVal < minusVal) cmpState[c] <= 1'b0;
    end

    AST_GT_GIVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpOn[c] && plusVal > minusVal) |=> cmpState[c]); // R10
    AST_LT_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpOn[c] && plusVal < minusVal) |=> !cmpState[c]); // R10
    AST_EQ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpOn[c] && plusVal == minusVal) |=> $stable(cmpState[c])); // R10
    AST_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !cmpOn[c] |=> !cmpState[c]); // R8
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA    <= '0;
      syncB    <= '0;
      lastRead <= '0;
      flag     <= 1'b0;
    end else begin
      syncA <= cmpState;
      syncB <= syncA;
      if (rdEn) lastRead <= syncB;
      if (syncB != lastRead && !rdEn) flag <= 1'b1;
      else if (flagClr)               flag <= 1'b0;
    end
  end

  assign status    = syncB;
  assign pinAnalog = ctl.pinAnalog;
  assign p3En      = ctl.driveOut;
  assign p3Data    = ctl.driveOut & syncB[0];
  assign p4En      = ctl.driveOut & ~syncB[1];
  assign p4Data    = 1'b0;

  AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    p4En |-> !p4Data); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flagClr) |=> flag); // R12
  AST_READ_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !flag) |=> !flag); // R12

endmodule

// File: rtl/cmp_route_top.sv
module cmp_route_top
  import cmp_route_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        regWrEn,
  input  logic [7:0]                  regWrData,
  input  logic                        regRdEn,
  output logic [7:0]                  regRdData,
  input  logic [PIN_COUNT*DATA_W-1:0] pinSamples,
  input  logic [DATA_W-1:0]           refCode,
  input  logic                        flagClr,
  output logic [PIN_COUNT-1:0]        analogMask,
  output logic                        pin3DriveEn,
  output logic                        pin3DriveData,
  output logic                        pin4DriveEn,
  output logic                        pin4DriveData,
  output logic                        changeFlag
);

  localparam int MODE_W = 3;

  routeCtl_t            ctl;
  logic [MODE_W-1:0]    modeVal;
  logic                 selVal;
  logic [CMP_COUNT-1:0] statusBits;
  logic                 unusedWrHigh;

  assign unusedWrHigh = ^regWrData[7:MODE_W+1];

  cmp_route_ctrl #(.MODE_W(MODE_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (regWrEn),
    .wrCfg   (regWrData[MODE_W:0]),
    .modeOut (modeVal),
    .selOut  (selVal),
    .ctl     (ctl)
  );

  cmp_route_dp #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pinBus    (pinSamples),
    .refCode   (refCode),
    .ctl       (ctl),
    .rdEn      (regRdEn),
    .flagClr   (flagClr),
    .status    (statusBits),
    .pinAnalog (analogMask),
    .p3En      (pin3DriveEn),
    .p3Data    (pin3DriveData),
    .p4En      (pin4DriveEn),
    .p4Data    (pin4DriveData),
    .flag      (changeFlag)
  );

  assign regRdData = {statusBits[1], statusBits[0], 2'b00, selVal, modeVal};

endmodule

// File: tb/cmp_route_top_tb_top.sv
module cmp_route_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regRdData;
  logic [31:0] pinSamples = '0;
  logic [7:0]  refCode = '0;
  logic        flagClr = 1'b0;
  logic [3:0]  analogMask;
  logic        pin3DriveEn, pin3DriveData, pin4DriveEn, pin4DriveData, changeFlag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  string       reqQ[$];
  logic [17:0] expQ[$];

  always #4 clk = ~clk;

  cmp_route_top dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .pinSamples(pinSamples),
    .refCode(refCode), .flagClr(flagClr), .analogMask(analogMask),
    .pin3DriveEn(pin3DriveEn), .pin3DriveData(pin3DriveData),
    .pin4DriveEn(pin4DriveEn), .pin4DriveData(pin4DriveData),
    .changeFlag(changeFlag)
  );

  task automatic expectObs(input string req, input logic [7:0] rd, input logic [3:0] am,
                           input logic [3:0] drv, input logic fl, input logic careFlag);
    reqQ.push_back(req);
    expQ.push_back({careFlag, rd, am, drv, fl});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        automatic logic [17:0] e = expQ.pop_front();
        automatic string r = reqQ.pop_front();
        automatic logic [16:0] act = {regRdData, analogMask, pin3DriveEn, pin3DriveData,
                                      pin4DriveEn, pin4DriveData, changeFlag};
        automatic logic [16:0] cmpMask = e[17] ? 17'h1FFFF : 17'h1FFFE;
        checks++;
        if ((act & cmpMask) !== (e[16:0] & cmpMask)) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", r, act & cmpMask, e[16:0] & cmpMask);
        end
      end
    end
  end

  task automatic setPins(input logic [7:0] p0, input logic [7:0] p1,
                         input logic [7:0] p2, input logic [7:0] p3);
    @(negedge clk);
    pinSamples = {p3, p2, p1, p0};
    repeat (6) @(posedge clk);
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic readClear();
    @(negedge clk);
    regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    expectObs("R1 R2 reset state", 8'h00, 4'b1111, 4'b0000, 1'b0, 1'b1);

    refCode = 8'd100;
    setPins(8'd10, 8'd50, 8'd60, 8'd20);
    writeReg(8'hF0);
    expectObs("R13 high write bits ignored in mode 000", 8'h00, 4'b1111, 4'b0000, 1'b0, 1'b1);

    writeReg(8'hF4);
    expectObs("R4 R13 R12 independent both high, flag set", 8'hC4, 4'b1111, 4'b0000, 1'b1, 1'b1);
    readClear();
    expectObs("R12 read then clear drops flag", 8'hC4, 4'b1111, 4'b0000, 1'b0, 1'b1);

    setPins(8'd10, 8'd50, 8'd60, 8'd5);
    expectObs("R4 R12 comparator 1 falls, flag set", 8'h84, 4'b1111, 4'b0000, 1'b1, 1'b1);
    readClear();

    @(negedge clk);
    pinSamples = {8'd5, 8'd40, 8'd50, 8'd10};
    repeat (2) @(posedge clk);
    expectObs("R11 status unchanged after two edges", 8'h84, 4'b1111, 4'b0000, 1'b0, 1'b0);
    @(posedge clk);
    expectObs("R11 status updated after third edge", 8'h04, 4'b1111, 4'b0000, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    readClear();

    setPins(8'd10, 8'd50, 8'd40, 8'd30);
    expectObs("R10 plus above minus gives one", 8'h44, 4'b1111, 4'b0000, 1'b0, 1'b0);
    setPins(8'd10, 8'd50, 8'd40, 8'd10);
    expectObs("R10 equal inputs hold one", 8'h44, 4'b1111, 4'b0000, 1'b0, 1'b0);
    setPins(8'd10, 8'd50, 8'd40, 8'd5);
    expectObs("R10 plus below minus gives zero", 8'h04, 4'b1111, 4'b0000, 1'b0, 1'b0);

    refCode = 8'd30;
    setPins(8'd10, 8'd50, 8'd20, 8'd40);
    writeReg(8'h02);
    expectObs("R5 reference mode select 0", 8'h42, 4'b1111, 4'b0000, 1'b0, 1'b0);
    writeReg(8'h0A);
    expectObs("R5 reference mode select 1", 8'h8A, 4'b1111, 4'b0000, 1'b0, 1'b0);

    writeReg(8'h03);
    expectObs("R6 common plus pin 2", 8'h43, 4'b0111, 4'b0000, 1'b0, 1'b0);

    writeReg(8'h06);
    expectObs("R7 outputs driven, pin 4 pulled low", 8'h46, 4'b0111, 4'b1110, 1'b0, 1'b0);
    setPins(8'd10, 8'd15, 8'd20, 8'd40);
    expectObs("R7 pin 4 released when comparator 2 high", 8'hC6, 4'b0111, 4'b1100, 1'b0, 1'b0);

    writeReg(8'h05);
    expectObs("R8 comparator 1 off, comparator 2 runs", 8'h85, 4'b0110, 4'b0000, 1'b0, 1'b0);

    writeReg(8'h01);
    expectObs("R9 three input mode select 0", 8'hC1, 4'b1111, 4'b0000, 1'b0, 1'b0);
    writeReg(8'h09);
    expectObs("R9 three input mode select 1", 8'h89, 4'b1111, 4'b0000, 1'b0, 1'b0);
    readClear();

    writeReg(8'h07);
    expectObs("R3 off mode all digital", 8'h07, 4'b0000, 4'b0000, 1'b1, 1'b1);
    writeReg(8'h00);
    expectObs("R2 back to reset mode", 8'h00, 4'b1111, 4'b0000, 1'b1, 1'b1);

    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    @(posedge clk);
    expectObs("R12 clear overridden while mismatch persists", 8'h00, 4'b1111, 4'b0000, 1'b1, 1'b1);
    readClear();
    expectObs("R12 read then clear drops flag", 8'h00, 4'b1111, 4'b0000, 1'b0, 1'b1);

    @(negedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule